// File: doc/BRIEF.md
# Sector-Block SCSI Transfer Engine

This block moves data between a one-block byte buffer and the 8-bit data lines of a SCSI bus, a whole block at a time, using the REQ/ACK byte handshake. A transfer starts with a length and a direction. In the send direction the host fills the buffer and the engine then clocks every byte out to the target. In the receive direction the engine fills the buffer from the bus and then hands it to the host to drain. A single buffer-ready flag tells the host when it owns the buffer.

The number of blocks is taken from the transfer length when the transfer starts. It is held in a narrow counter that wraps on overflow. After each block the engine gives the buffer back to the host. When the counter runs out, the engine raises end-of-DMA, marks the last byte sent for send transfers, and raises an interrupt if that is enabled. If BSY goes away while bus monitoring is switched on, the transfer stops and the engine returns to idle.

Top module: `sblk_xfer_engine`

## Requirements
- R1: After reset, ack_out, data_oe, buf_ready, blk_loaded, dma_active, end_of_dma, last_byte_sent and irq are all 0, blocks_left is 0, and host_rdata reads all ones.
- R2: A start with a nonzero length loads blocks_left with the length shifted right by BLK_AW, cut to CNT_W bits. If the length is below 2^BLK_AW, blocks_left is forced to 1. A start with length 0 is ignored. If start_send and start_recv come together, start_send wins.
- R3: The block length is the transfer length when that is below 2^BLK_AW, and 2^BLK_AW otherwise. Any bytes past the last whole block are not moved.
- R4: Send: buf_ready is 1 in the cycle after the start. Each accepted host_wr stores one byte. When the block is full, buf_ready drops and the engine drives the bytes on data_out in write order. ACK is high for exactly one cycle per byte, and data_out stays steady while ACK is high.
- R5: Receive: the engine captures data_in for each byte in the cycle that moves the byte, then pulses ACK. Once the block is filled, buf_ready rises and the host reads the bytes in bus order through host_rdata, advancing one byte per host_rd.
- R6: For each byte the engine waits for REQ for at most REQ_POLLS cycles. With REQ high, ACK rises in the second cycle after the edge that sets buf_ready low. With REQ held low, the byte is moved anyway and ACK rises REQ_POLLS+1 edges after that edge.
- R7: At each block boundary blocks_left decreases by one, wrapping modulo 2^CNT_W. A loaded count of 0 therefore yields 2^CNT_W blocks. If more blocks remain, buf_ready is set again and the host pointer restarts at byte 0.
- R8: When the final block finishes, end_of_dma is set and blk_loaded is cleared. last_byte_sent is set only for send transfers. All three flags go back to their start values at the next accepted start.
- R9: irq is set at completion only if eop_irq_en is 1.
- R10: While mon_bsy_en is 1, a low bsy_in returns the engine to idle at the next edge. This clears dma_active, blk_loaded and buf_ready, and no further ACK is issued. With mon_bsy_en at 0, bsy_in has no effect.
- R11: Host writes and reads are ignored while buf_ready is 0. A read then returns all ones, and a write does not change the bytes sent on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_send | input | 1 | Start a send transfer (one-cycle pulse) |
| start_recv | input | 1 | Start a receive transfer (one-cycle pulse) |
| xfer_len | input | LEN_W | Total transfer length in bytes |
| mon_bsy_en | input | 1 | Abort the transfer when BSY drops |
| eop_irq_en | input | 1 | Enable the completion interrupt |
| host_wr | input | 1 | Host byte write strobe (send) |
| host_wdata | input | DATA_W | Host write byte |
| host_rd | input | 1 | Host byte read strobe (receive) |
| host_rdata | output | DATA_W | Byte at the host pointer, or all ones when not readable |
| buf_ready | output | 1 | The host owns the buffer |
| req_in | input | 1 | SCSI REQ from the target |
| bsy_in | input | 1 | SCSI BSY |
| data_in | input | DATA_W | SCSI data lines, inbound |
| data_out | output | DATA_W | SCSI data lines, outbound |
| data_oe | output | 1 | Drive data_out onto the bus |
| ack_out | output | 1 | SCSI ACK |
| blocks_left | output | CNT_W | Blocks still to move |
| blk_loaded | output | 1 | A transfer is in progress |
| dma_active | output | 1 | DMA mode, cleared by a BSY abort |
| end_of_dma | output | 1 | Transfer complete |
| last_byte_sent | output | 1 | Send transfer complete |
| irq | output | 1 | Completion interrupt |

## Verification
blocks_left and buf_ready are due one edge after the start is taken. ACK is due two edges after the edge that takes the last host byte when REQ is present, and REQ_POLLS+1 edges after it when REQ is absent. The end of a BSY abort shows one edge after bsy_in falls. The bench drives inputs and samples outputs at the falling clock edge. It counts edges from the stimulus to the exact edge where each result is due. Transfer data and byte counts are compared against totals the bench computes from the length, the block size and the wrapping counter width, over a sweep of lengths in both directions.

// File: rtl/sblk_pkg.sv
// Package: shared type for the block transfer engine.
// Assumes: nothing beyond IEEE 1800-2017.
package sblk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT_READY = 3'd1,
        ST_WAIT_REQ   = 3'd2,
        ST_ACK_HIGH   = 3'd3,
        ST_ACK_LOW    = 3'd4,
        ST_BLOCK_DONE = 3'd5
    } xfer_state_t;

endpackage

// File: rtl/sblk_block_counter.sv
// Block counter: at start it loads the number of blocks and the bytes per
// block from the transfer length, and it counts down one block per pulse,
// wrapping modulo 2^CNT_W.
// Assumes: LEN_W > BLK_AW; load and dec are never high together.
module sblk_block_counter #(
    parameter int LEN_W  = 17,
    parameter int CNT_W  = 8,
    parameter int BLK_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dec,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic [CNT_W-1:0]  blocks_left,
    output logic [BLK_AW:0]   blk_len,
    output logic              last_block
);
    localparam int BLK_BYTES = 1 << BLK_AW;

    logic              short_xfer;
    logic [LEN_W-1:0]  len_blocks;
    logic [CNT_W-1:0]  cnt_init;
    logic [BLK_AW:0]   len_init;

    // Work out the values loaded at the start of a transfer
    always_comb begin
        short_xfer = xfer_len < LEN_W'(BLK_BYTES);
        len_blocks = xfer_len >> BLK_AW;
        cnt_init   = short_xfer ? CNT_W'(1) : CNT_W'(len_blocks);
        len_init   = short_xfer ? xfer_len[BLK_AW:0] : (BLK_AW+1)'(BLK_BYTES);
    end

    // Load at start, count down one block per pulse with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocks_left <= '0;
            blk_len     <= '0;
        end else if (load) begin
            blocks_left <= cnt_init;
            blk_len     <= len_init;
        end else if (dec) begin
            blocks_left <= blocks_left - CNT_W'(1);
        end
    end

    assign last_block = (blocks_left == CNT_W'(1));

endmodule

// File: rtl/sblk_buffer.sv
// Block buffer: one write port and two read ports with asynchronous reads.
// Port A serves the bus side and port B the host side.
// Assumes: the write-port mux outside ensures a single writer per cycle.
module sblk_buffer #(
    parameter int DATA_W = 8,
    parameter int BLK_AW = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BLK_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BLK_AW-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [BLK_AW-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << BLK_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte per cycle
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/sblk_host_port.sv
// Host side of the buffer: keeps the host byte pointer and the buffer-ready
// flag. The host may write (send) or read (receive) only while ready is set.
// The flag drops once the last byte of the block is taken.
// Assumes: refill only arrives while ready is low.
module sblk_host_port #(
    parameter int BLK_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_send,
    input  logic              start_recv,
    input  logic              abort,
    input  logic              refill,
    input  logic              dir_send,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BLK_AW:0]   blk_len,
    output logic [BLK_AW-1:0] host_ptr,
    output logic              buf_ready,
    output logic              host_we
);
    logic host_take;
    logic at_last;

    // Decode which host strobes are accepted this cycle
    always_comb begin
        host_we   = host_wr && buf_ready && dir_send;
        host_take = host_rd && buf_ready && !dir_send;
        at_last   = {1'b0, host_ptr} == (blk_len - (BLK_AW+1)'(1));
    end

    // Move the host pointer and hand buffer ownership back and forth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ptr  <= '0;
            buf_ready <= 1'b0;
        end else if (abort) begin
            host_ptr  <= '0;
            buf_ready <= 1'b0;
        end else if (start_send) begin
            host_ptr  <= '0;
            buf_ready <= 1'b1;
        end else if (start_recv) begin
            host_ptr  <= '0;
            buf_ready <= 1'b0;
        end else if (refill) begin
            host_ptr  <= '0;
            buf_ready <= 1'b1;
        end else if (host_we || host_take) begin
            if (at_last) begin
                host_ptr  <= '0;
                buf_ready <= 1'b0;
            end else begin
                host_ptr  <= host_ptr + BLK_AW'(1);
            end
        end
    end

endmodule

// File: rtl/sblk_fsm.sv
// Handshake sequencer: waits until the host has released the buffer, then
// for each byte polls REQ up to REQ_POLLS cycles and gives a one-cycle ACK.
// At block end it updates the block count and at the final block it raises
// the completion flags. A BSY drop under monitoring forces idle.
// Assumes: blk_len is nonzero whenever a transfer is running.
module sblk_fsm #(
    parameter int BLK_AW    = 9,
    parameter int REQ_POLLS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_send,
    input  logic              start_recv,
    input  logic              len_nonzero,
    input  logic              mon_bsy_en,
    input  logic              bsy_in,
    input  logic              req_in,
    input  logic              eop_irq_en,
    input  logic              buf_ready,
    input  logic [BLK_AW:0]   blk_len,
    input  logic              last_block,
    output logic              ack_out,
    output logic              data_oe,
    output logic              dir_send,
    output logic [BLK_AW-1:0] byte_ptr,
    output logic              eng_we,
    output logic              accept_send,
    output logic              accept_recv,
    output logic              cnt_dec,
    output logic              refill,
    output logic              abort,
    output logic              blk_loaded,
    output logic              dma_active,
    output logic              end_of_dma,
    output logic              last_byte_sent,
    output logic              irq
);
    import sblk_pkg::*;

    localparam int POLL_W = $clog2(REQ_POLLS + 1);

    xfer_state_t       state;
    logic [POLL_W-1:0] poll_cnt;
    logic              accept;
    logic              move;
    logic              byte_last;

    // Decode the events of this cycle
    always_comb begin
        abort       = mon_bsy_en && !bsy_in;
        accept      = (state == ST_IDLE) && !abort && len_nonzero && (start_send || start_recv);
        accept_send = accept && start_send;
        accept_recv = accept && !start_send;
        move        = (state == ST_WAIT_REQ) && !abort &&
                      (req_in || (poll_cnt == POLL_W'(REQ_POLLS - 1)));
        eng_we      = move && !dir_send;
        byte_last   = {1'b0, byte_ptr} == (blk_len - (BLK_AW+1)'(1));
        cnt_dec     = (state == ST_BLOCK_DONE) && !abort;
        refill      = cnt_dec && (!last_block || !dir_send);
        ack_out     = (state == ST_ACK_HIGH);
        data_oe     = dir_send && ((state == ST_WAIT_REQ) || (state == ST_ACK_HIGH) ||
                                   (state == ST_ACK_LOW));
    end

    // Step the state machine, byte pointer, REQ poll counter and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            poll_cnt       <= '0;
            byte_ptr       <= '0;
            dir_send       <= 1'b0;
            blk_loaded     <= 1'b0;
            dma_active     <= 1'b0;
            end_of_dma     <= 1'b0;
            last_byte_sent <= 1'b0;
            irq            <= 1'b0;
        end else if (abort) begin
            state      <= ST_IDLE;
            poll_cnt   <= '0;
            byte_ptr   <= '0;
            blk_loaded <= 1'b0;
            dma_active <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state          <= ST_WAIT_READY;
                        dir_send       <= start_send;
                        byte_ptr       <= '0;
                        blk_loaded     <= 1'b1;
                        dma_active     <= 1'b1;
                        end_of_dma     <= 1'b0;
                        last_byte_sent <= 1'b0;
                        irq            <= 1'b0;
                    end
                end
                ST_WAIT_READY: begin
                    if (!buf_ready) begin
                        state    <= ST_WAIT_REQ;
                        poll_cnt <= '0;
                    end
                end
                ST_WAIT_REQ: begin
                    if (move) begin
                        state    <= ST_ACK_HIGH;
                        poll_cnt <= '0;
                    end else begin
                        poll_cnt <= poll_cnt + POLL_W'(1);
                    end
                end
                ST_ACK_HIGH: begin
                    state <= ST_ACK_LOW;
                end
                ST_ACK_LOW: begin
                    if (byte_last) begin
                        state    <= ST_BLOCK_DONE;
                        byte_ptr <= '0;
                    end else begin
                        state    <= ST_WAIT_REQ;
                        byte_ptr <= byte_ptr + BLK_AW'(1);
                    end
                end
                ST_BLOCK_DONE: begin
                    if (last_block) begin
                        state          <= ST_IDLE;
                        blk_loaded     <= 1'b0;
                        end_of_dma     <= 1'b1;
                        last_byte_sent <= dir_send;
                        irq            <= eop_irq_en;
                    end else begin
                        state <= ST_WAIT_READY;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sblk_xfer_engine.sv
// Top level: connects the block counter, buffer, host port and handshake
// sequencer. The bus side and the host side share one write port, and the
// buffer-ready flag decides which side owns it.
// Assumes: LEN_W > BLK_AW; the host strobes bytes only while buf_ready is set.
module sblk_xfer_engine #(
    parameter int DATA_W    = 8,
    parameter int BLK_AW    = 9,
    parameter int LEN_W     = 17,
    parameter int CNT_W     = 8,
    parameter int REQ_POLLS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_send,
    input  logic              start_recv,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              mon_bsy_en,
    input  logic              eop_irq_en,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              buf_ready,
    input  logic              req_in,
    input  logic              bsy_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              ack_out,
    output logic [CNT_W-1:0]  blocks_left,
    output logic              blk_loaded,
    output logic              dma_active,
    output logic              end_of_dma,
    output logic              last_byte_sent,
    output logic              irq
);
    logic              dir_send;
    logic [BLK_AW-1:0] byte_ptr;
    logic [BLK_AW-1:0] host_ptr;
    logic [BLK_AW:0]   blk_len;
    logic              last_block;
    logic              eng_we, host_we;
    logic              accept_send, accept_recv;
    logic              cnt_dec, refill, abort;
    logic              buf_we;
    logic [BLK_AW-1:0] buf_waddr;
    logic [DATA_W-1:0] buf_wdata;
    logic [DATA_W-1:0] rdata_bus, rdata_host;

    sblk_block_counter #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W),
        .BLK_AW(BLK_AW)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept_send || accept_recv),
        .dec        (cnt_dec),
        .xfer_len   (xfer_len),
        .blocks_left(blocks_left),
        .blk_len    (blk_len),
        .last_block (last_block)
    );

    sblk_fsm #(
        .BLK_AW   (BLK_AW),
        .REQ_POLLS(REQ_POLLS)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_send    (start_send),
        .start_recv    (start_recv),
        .len_nonzero   (xfer_len != '0),
        .mon_bsy_en    (mon_bsy_en),
        .bsy_in        (bsy_in),
        .req_in        (req_in),
        .eop_irq_en    (eop_irq_en),
        .buf_ready     (buf_ready),
        .blk_len       (blk_len),
        .last_block    (last_block),
        .ack_out       (ack_out),
        .data_oe       (data_oe),
        .dir_send      (dir_send),
        .byte_ptr      (byte_ptr),
        .eng_we        (eng_we),
        .accept_send   (accept_send),
        .accept_recv   (accept_recv),
        .cnt_dec       (cnt_dec),
        .refill        (refill),
        .abort         (abort),
        .blk_loaded    (blk_loaded),
        .dma_active    (dma_active),
        .end_of_dma    (end_of_dma),
        .last_byte_sent(last_byte_sent),
        .irq           (irq)
    );

    sblk_host_port #(
        .BLK_AW(BLK_AW)
    ) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_send(accept_send),
        .start_recv(accept_recv),
        .abort     (abort),
        .refill    (refill),
        .dir_send  (dir_send),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .blk_len   (blk_len),
        .host_ptr  (host_ptr),
        .buf_ready (buf_ready),
        .host_we   (host_we)
    );

    // Pick the single writer of the buffer this cycle
    always_comb begin
        buf_we    = eng_we || host_we;
        buf_waddr = eng_we ? byte_ptr : host_ptr;
        buf_wdata = eng_we ? data_in : host_wdata;
    end

    sblk_buffer #(
        .DATA_W(DATA_W),
        .BLK_AW(BLK_AW)
    ) u_buf (
        .clk    (clk),
        .we     (buf_we),
        .waddr  (buf_waddr),
        .wdata  (buf_wdata),
        .raddr_a(byte_ptr),
        .rdata_a(rdata_bus),
        .raddr_b(host_ptr),
        .rdata_b(rdata_host)
    );

    assign data_out   = data_oe ? rdata_bus : '0;
    assign host_rdata = (buf_ready && !dir_send) ? rdata_host : '1;

endmodule

// File: rtl/sblk_xfer_engine_chk.sv
// Checker: temporal properties of the engine's ports, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module sblk_xfer_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mon_bsy_en,
    input logic              bsy_in,
    input logic              eop_irq_en,
    input logic              ack_out,
    input logic [DATA_W-1:0] data_out,
    input logic              buf_ready,
    input logic              blk_loaded,
    input logic              dma_active,
    input logic              end_of_dma,
    input logic              last_byte_sent,
    input logic              irq
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |=> !ack_out);                                          // R4
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |-> $stable(data_out));                                 // R4
    AST_HOST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |-> !buf_ready);                                        // R11
    AST_BSY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_bsy_en && !bsy_in) |=> (!dma_active && !blk_loaded && !ack_out)); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (end_of_dma && $past(eop_irq_en)));              // R9
    AST_LBS_WITH_EOD: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte_sent |-> end_of_dma);                                 // R8
    AST_DONE_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_of_dma) |-> !blk_loaded);                             // R8
endmodule

bind sblk_xfer_engine sblk_xfer_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mon_bsy_en    (mon_bsy_en),
    .bsy_in        (bsy_in),
    .eop_irq_en    (eop_irq_en),
    .ack_out       (ack_out),
    .data_out      (data_out),
    .buf_ready     (buf_ready),
    .blk_loaded    (blk_loaded),
    .dma_active    (dma_active),
    .end_of_dma    (end_of_dma),
    .last_byte_sent(last_byte_sent),
    .irq           (irq)
);

// File: tb/sim_sblk_xfer_engine.sv
module sim_sblk_xfer_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int BLK_AW     = 3;
    localparam int LEN_W      = 7;
    localparam int CNT_W      = 3;
    localparam int POLLS      = 4;
    localparam int BLK        = 1 << BLK_AW;
    localparam int CMOD       = 1 << CNT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_send = 1'b0, start_recv = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic mon_bsy_en = 1'b0, eop_irq_en = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic buf_ready;
    logic req_in = 1'b1, bsy_in = 1'b1;
    logic [DATA_W-1:0] data_in;
    logic [DATA_W-1:0] data_out;
    logic data_oe, ack_out;
    logic [CNT_W-1:0] blocks_left;
    logic blk_loaded, dma_active, end_of_dma, last_byte_sent, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ack_total = 0;
    int base = 0;
    int seed = 0;
    logic [DATA_W-1:0] captured [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    sblk_xfer_engine #(
        .DATA_W(DATA_W), .BLK_AW(BLK_AW), .LEN_W(LEN_W),
        .CNT_W(CNT_W), .REQ_POLLS(POLLS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_send(start_send), .start_recv(start_recv),
        .xfer_len(xfer_len), .mon_bsy_en(mon_bsy_en), .eop_irq_en(eop_irq_en),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .buf_ready(buf_ready), .req_in(req_in),
        .bsy_in(bsy_in), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .ack_out(ack_out), .blocks_left(blocks_left), .blk_loaded(blk_loaded),
        .dma_active(dma_active), .end_of_dma(end_of_dma),
        .last_byte_sent(last_byte_sent), .irq(irq)
    );

    function automatic logic [DATA_W-1:0] pat(int k, int s);
        return DATA_W'(k * 37 + s * 11 + 5);
    endfunction

    // Target model: presents byte k of the run, records bytes on ACK
    assign data_in = pat(ack_total - base, seed);

    always @(negedge clk) begin
        if (ack_out) begin
            captured[ack_total % 256] <= data_out;
            ack_total <= ack_total + 1;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            finish_run();
        end
    end

    function automatic int exp_cnt(int len);
        return (len < BLK) ? 1 : ((len >> BLK_AW) % CMOD);
    endfunction

    function automatic int exp_blocks(int len);
        int c;
        c = exp_cnt(len);
        return (c == 0) ? CMOD : c;
    endfunction

    function automatic int exp_blen(int len);
        return (len < BLK) ? len : BLK;
    endfunction

    task automatic wait_ready();
        for (int i = 0; i < 2000 && !buf_ready; i++) @(negedge clk);
    endtask

    task automatic wait_eod();
        for (int i = 0; i < 2000 && !end_of_dma; i++) @(negedge clk);
    endtask

    task automatic pulse_start(bit send, int len);
        xfer_len = LEN_W'(len);
        if (send) start_send = 1'b1; else start_recv = 1'b1;
        @(negedge clk);
        start_send = 1'b0;
        start_recv = 1'b0;
    endtask

    task automatic run_send(int len, bit eop);
        int nblk, blen, bad;
        nblk = exp_blocks(len);
        blen = exp_blen(len);
        seed = len;
        eop_irq_en = eop;
        base = ack_total;
        pulse_start(1'b1, len);
        chk(int'(blocks_left) == exp_cnt(len), "R2 send block count", int'(blocks_left), exp_cnt(len));
        chk(buf_ready == 1'b1 && end_of_dma == 1'b0, "R4/R8 send start", int'(buf_ready), 1);
        for (int b = 0; b < nblk; b++) begin
            wait_ready();
            for (int i = 0; i < blen; i++) begin
                host_wr = 1'b1;
                host_wdata = pat(b * blen + i, seed);
                @(negedge clk);
            end
            // R11: write while not ready must be dropped
            host_wdata = ~pat(b * blen, seed);
            @(negedge clk);
            host_wr = 1'b0;
        end
        wait_eod();
        @(negedge clk);
        bad = 0;
        for (int k = 0; k < nblk * blen; k++)
            if (captured[(base + k) % 256] !== pat(k, seed)) bad++;
        chk(ack_total - base == nblk * blen, "R3/R7 send byte total", ack_total - base, nblk * blen);
        chk(bad == 0, "R4/R11 send data order", bad, 0);
        chk(end_of_dma && last_byte_sent && !blk_loaded, "R8 send completion flags",
            {end_of_dma, last_byte_sent, blk_loaded}, 3'b110);
        chk(irq == eop, "R9 send irq gating", int'(irq), int'(eop));
        chk(blocks_left == '0, "R7 send count exhausted", int'(blocks_left), 0);
    endtask

    task automatic run_recv(int len, bit eop);
        int nblk, blen, bad;
        nblk = exp_blocks(len);
        blen = exp_blen(len);
        seed = len + 100;
        eop_irq_en = eop;
        base = ack_total;
        pulse_start(1'b0, len);
        chk(int'(blocks_left) == exp_cnt(len), "R2 recv block count", int'(blocks_left), exp_cnt(len));
        chk(host_rdata == '1, "R11 read while not ready", int'(host_rdata), 255);
        bad = 0;
        for (int b = 0; b < nblk; b++) begin
            wait_ready();
            for (int i = 0; i < blen; i++) begin
                if (host_rdata !== pat(b * blen + i, seed)) bad++;
                host_rd = 1'b1;
                @(negedge clk);
            end
            host_rd = 1'b0;
        end
        wait_eod();
        @(negedge clk);
        chk(bad == 0, "R5 recv data order", bad, 0);
        chk(ack_total - base == nblk * blen, "R3/R7 recv byte total", ack_total - base, nblk * blen);
        chk(end_of_dma && !last_byte_sent && !blk_loaded, "R8 recv completion flags",
            {end_of_dma, last_byte_sent, blk_loaded}, 3'b100);
        chk(irq == eop, "R9 recv irq gating", int'(irq), int'(eop));
    endtask

    // R6: edges from the last host byte to the first visible ACK
    task automatic poll_case(bit req_level, int exp_n);
        int n;
        req_in = req_level;
        seed = 7;
        base = ack_total;
        pulse_start(1'b1, 1);
        wait_ready();
        host_wr = 1'b1;
        host_wdata = 8'h5A;
        @(negedge clk);
        host_wr = 1'b0;
        n = 1;
        while (!ack_out && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_n, "R6 REQ poll timing", n, exp_n);
        wait_eod();
        @(negedge clk);
        chk(captured[base % 256] == 8'h5A, "R6 byte moved", int'(captured[base % 256]), 90);
        req_in = 1'b1;
    endtask

    initial begin
        int acks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({ack_out, data_oe, buf_ready, blk_loaded, dma_active, end_of_dma,
             last_byte_sent, irq} == 8'h00, "R1 reset flags", 0, 0);
        chk(blocks_left == '0, "R1 reset count", int'(blocks_left), 0);
        chk(host_rdata == '1, "R1 reset read data", int'(host_rdata), 255);

        // R2 zero length start is ignored
        pulse_start(1'b1, 0);
        chk(!dma_active && !buf_ready && blocks_left == '0, "R2 zero length ignored",
            int'(dma_active), 0);

        // R6 REQ present and REQ absent
        poll_case(1'b1, 3);
        poll_case(1'b0, POLLS + 2);

        // Sweep lengths in both directions, including counter wrap
        for (int len = 1; len <= 80; len++) begin
            run_send(len, len[0]);
            run_recv(len, ~len[0]);
        end

        // R10 abort under BSY monitoring
        mon_bsy_en = 1'b1;
        seed = 3;
        base = ack_total;
        pulse_start(1'b0, 24);
        repeat (5) @(negedge clk);
        bsy_in = 1'b0;
        @(negedge clk);
        chk(!dma_active && !blk_loaded && !buf_ready && !ack_out && !end_of_dma,
            "R10 BSY abort", int'(dma_active), 0);
        bsy_in = 1'b1;
        acks = ack_total;
        repeat (20) @(negedge clk);
        chk(ack_total == acks, "R10 no ACK after abort", ack_total - acks, 0);

        // R10 BSY low without monitoring has no effect
        mon_bsy_en = 1'b0;
        bsy_in = 1'b0;
        run_send(16, 1'b1);
        bsy_in = 1'b1;

        finish_run();
    end
endmodule